// File: doc/BRIEF.md
# Acknowledge-Polling Write Completion Sequencer

This block runs on the master side of a two-wire serial bus. It sits above a byte-level bus master engine and answers one question: has the memory device finished its internal write cycle? A fixed worst-case delay would waste time. Instead, the sequencer keeps probing the device. Each probe is a start condition followed by the device address with the read/write bit cleared. A device that is still busy does not acknowledge its address, and the sequencer probes again after a short programmable gap. The first acknowledge ends the wait.

What happens after the acknowledge depends on the request. If the next operation is a write, the sequencer sends the word address and leaves the transfer open, with no stop, so the caller can stream data bytes at once. Otherwise it closes the bus with a stop so that a different operation can start fresh. If a retry limit is set and the device never answers within it, the sequencer stops the bus and reports a timeout.

Requests arrive on a valid/ready port. A request is taken on a cycle where both `req_valid` and `req_ready` are high. `req_ready` stays low until the sequence has finished, so the caller holds its request until then. Commands leave on a second valid/ready port toward the byte engine. Once a command is presented, it and its payload stay unchanged until the engine accepts it. The engine returns one response pulse per command, and for a sent byte that response carries the acknowledge bit.

Top module: `ackpoll_seq`

## Requirements
- R1: After reset, and whenever reset is applied mid-sequence, `req_ready` is high and both `cmd_valid` and `done` are low.
- R2: Once `cmd_valid` is raised, `cmd_valid`, `cmd_op` and `cmd_data` stay unchanged until a cycle in which `cmd_ready` is high. While `req_ready` is high, no command is presented.
- R3: Each poll attempt presents a start command (`cmd_op` = 2'b00) followed by a send command (`cmd_op` = 2'b01). The send command carries the byte {DEV_ADDR, 1'b0}.
- R4: A not-acknowledged address response causes a new poll attempt. Its start command is first presented exactly GAP_CYCLES+1 cycles after the cycle of that response.
- R5: An acknowledged address on a write request makes the sequencer send the word address byte and issue no stop. `xfer_open` is high during the `done` cycle.
- R6: An acknowledged address on a non-write request makes the sequencer issue one stop command (`cmd_op` = 2'b10) and send no word address. `xfer_open` is low during the `done` cycle.
- R7: With MAX_POLLS nonzero, the MAX_POLLS-th consecutive not-acknowledged response ends polling with one stop command. `timeout` is then high during the `done` cycle, and no further start is presented.
- R8: `done` is a single-cycle pulse, given once per request. It is raised only while `eng_idle` is high, and exactly one cycle after the final response if the engine is already idle, otherwise in the first cycle the engine reports idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Sequencer can take a request |
| req_is_write | input | 1 | Next operation is a write |
| req_word_addr | input | 8 | Word address for a following write |
| cmd_valid | output | 1 | Command presented to byte engine |
| cmd_ready | input | 1 | Byte engine accepts the command |
| cmd_op | output | 2 | 00 start, 01 send byte, 10 stop |
| cmd_data | output | 8 | Byte for a send command |
| rsp_valid | input | 1 | Byte engine finished a command |
| rsp_ack | input | 1 | Byte was acknowledged (valid with rsp_valid) |
| eng_idle | input | 1 | Byte engine has nothing in flight |
| done | output | 1 | One-cycle end-of-sequence pulse |
| timeout | output | 1 | Retry limit reached (valid with done) |
| xfer_open | output | 1 | Transfer left open for a write (valid with done) |

## Verification
The assertions check on every cycle the rules that hold whatever the device does. They cover the command hold under back-pressure, the silence of the command port while idle, the single-cycle `done` tied to an idle engine, and a timeout that never comes with an open transfer. Some properties depend on counts and on the device's reply pattern: the exact gap after each refusal, the number of attempts, the choice between word address and stop, the timeout at the limit, and the delay of `done` behind a slow engine. Only the bench's scenarios can show these, and it drives them with a scripted byte engine that refuses a chosen number of times.

// File: rtl/ackpoll_pkg.sv
package ackpoll_pkg;

  typedef enum logic [1:0] {
    OP_START = 2'b00,
    OP_SEND  = 2'b01,
    OP_STOP  = 2'b10
  } eng_op_e;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_START,
    ST_START_W,
    ST_ADDR,
    ST_ADDR_W,
    ST_GAP,
    ST_WORD,
    ST_WORD_W,
    ST_STOP,
    ST_STOP_W,
    ST_FIN
  } seq_state_e;

endpackage

// File: rtl/ackpoll_gap_timer.sv
// Counts the idle gap between a refused address and the next start.
module ackpoll_gap_timer #(
  parameter int GAP_CYCLES = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic load,
  output logic expired
);
  localparam int W = $clog2(GAP_CYCLES + 2);

  logic [W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt <= '0;
    end else if (load) begin
      cnt <= W'(GAP_CYCLES);
    end else if (cnt != '0) begin
      cnt <= cnt - 1'b1;
    end
  end

  // Last waiting cycle: the FSM moves on at the following edge.
  assign expired = (cnt == W'(1));
endmodule

// File: rtl/ackpoll_retry_limit.sv
// Counts refused polls; flags the refusal that reaches the limit.
module ackpoll_retry_limit #(
  parameter int MAX_POLLS = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clear,
  input  logic bump,
  output logic last
);
  localparam int W   = $clog2(MAX_POLLS + 2);
  localparam int LIM = (MAX_POLLS == 0) ? 0 : MAX_POLLS - 1;

  logic [W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt <= '0;
    end else if (clear) begin
      cnt <= '0;
    end else if (bump && (cnt != W'(LIM))) begin
      cnt <= cnt + 1'b1;
    end
  end

  generate
    if (MAX_POLLS == 0) begin : g_unlimited
      assign last = 1'b0;
    end else begin : g_limited
      assign last = bump && (cnt == W'(LIM));
    end
  endgenerate
endmodule

// File: rtl/ackpoll_seq.sv
module ackpoll_seq
  import ackpoll_pkg::*;
#(
  parameter logic [6:0] DEV_ADDR   = 7'h50,
  parameter int         BYTE_W     = 8,
  parameter int         MAX_POLLS  = 8,
  parameter int         GAP_CYCLES = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_is_write,
  input  logic [BYTE_W-1:0] req_word_addr,
  output logic              cmd_valid,
  input  logic              cmd_ready,
  output logic [1:0]        cmd_op,
  output logic [BYTE_W-1:0] cmd_data,
  input  logic              rsp_valid,
  input  logic              rsp_ack,
  input  logic              eng_idle,
  output logic              done,
  output logic              timeout,
  output logic              xfer_open
);
  localparam logic [BYTE_W-1:0] PROBE_BYTE = BYTE_W'({DEV_ADDR, 1'b0});
  localparam bit                NO_GAP     = (GAP_CYCLES == 0);

  seq_state_e        state, state_nx;
  logic              wr_q;
  logic [BYTE_W-1:0] word_q;
  logic              to_q, to_set;
  logic              accept, refused, gap_load, gap_done, poll_last;

  assign accept  = (state == ST_IDLE) && req_valid;
  assign refused = (state == ST_ADDR_W) && rsp_valid && !rsp_ack;

  ackpoll_gap_timer #(.GAP_CYCLES(GAP_CYCLES)) u_gap (
    .clk     (clk),
    .rst_n   (rst_n),
    .load    (gap_load),
    .expired (gap_done)
  );

  ackpoll_retry_limit #(.MAX_POLLS(MAX_POLLS)) u_retry (
    .clk   (clk),
    .rst_n (rst_n),
    .clear (accept),
    .bump  (refused),
    .last  (poll_last)
  );

  always_comb begin
    state_nx = state;
    gap_load = 1'b0;
    to_set   = 1'b0;
    unique case (state)
      ST_IDLE:    if (req_valid) state_nx = ST_START;
      ST_START:   if (cmd_ready) state_nx = ST_START_W;
      ST_START_W: if (rsp_valid) state_nx = ST_ADDR;
      ST_ADDR:    if (cmd_ready) state_nx = ST_ADDR_W;
      ST_ADDR_W: begin
        if (rsp_valid) begin
          if (rsp_ack) begin
            state_nx = wr_q ? ST_WORD : ST_STOP;
          end else if (poll_last) begin
            to_set   = 1'b1;
            state_nx = ST_STOP;
          end else if (NO_GAP) begin
            state_nx = ST_START;
          end else begin
            gap_load = 1'b1;
            state_nx = ST_GAP;
          end
        end
      end
      ST_GAP:     if (gap_done) state_nx = ST_START;
      ST_WORD:    if (cmd_ready) state_nx = ST_WORD_W;
      ST_WORD_W:  if (rsp_valid) state_nx = ST_FIN;
      ST_STOP:    if (cmd_ready) state_nx = ST_STOP_W;
      ST_STOP_W:  if (rsp_valid) state_nx = ST_FIN;
      ST_FIN:     if (eng_idle) state_nx = ST_IDLE;
      default:    state_nx = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state  <= ST_IDLE;
      wr_q   <= 1'b0;
      word_q <= '0;
      to_q   <= 1'b0;
    end else begin
      state <= state_nx;
      if (accept) begin
        wr_q   <= req_is_write;
        word_q <= req_word_addr;
        to_q   <= 1'b0;
      end else if (to_set) begin
        to_q <= 1'b1;
      end
    end
  end

  // Command port
  always_comb begin
    cmd_valid = 1'b0;
    cmd_op    = OP_START;
    cmd_data  = '0;
    unique case (state)
      ST_START: cmd_valid = 1'b1;
      ST_ADDR: begin
        cmd_valid = 1'b1;
        cmd_op    = OP_SEND;
        cmd_data  = PROBE_BYTE;
      end
      ST_WORD: begin
        cmd_valid = 1'b1;
        cmd_op    = OP_SEND;
        cmd_data  = word_q;
      end
      ST_STOP: begin
        cmd_valid = 1'b1;
        cmd_op    = OP_STOP;
      end
      default: ;
    endcase
  end

  assign req_ready = (state == ST_IDLE);
  assign done      = (state == ST_FIN) && eng_idle;
  assign timeout   = done && to_q;
  assign xfer_open = done && wr_q && !to_q;
endmodule

// File: rtl/ackpoll_seq_chk.sv
module ackpoll_seq_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       req_ready,
  input logic       cmd_valid,
  input logic       cmd_ready,
  input logic [1:0] cmd_op,
  input logic [7:0] cmd_data,
  input logic       eng_idle,
  input logic       done,
  input logic       timeout,
  input logic       xfer_open
);
  // R2
  cmd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && !cmd_ready) |=> (cmd_valid && $stable(cmd_op) && $stable(cmd_data)));

  // R2
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> !cmd_valid);

  // R8
  done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R8
  done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> eng_idle);

  // R7
  timeout_closed_chk: assert property (@(posedge clk) disable iff (!rst_n)
    timeout |-> (done && !xfer_open));
endmodule

bind ackpoll_seq ackpoll_seq_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .req_ready (req_ready),
  .cmd_valid (cmd_valid),
  .cmd_ready (cmd_ready),
  .cmd_op    (cmd_op),
  .cmd_data  (cmd_data),
  .eng_idle  (eng_idle),
  .done      (done),
  .timeout   (timeout),
  .xfer_open (xfer_open)
);

// File: tb/ackpoll_seq_test.sv
module ackpoll_seq_test;
  localparam int         TB_MAX   = 5;
  localparam int         TB_GAP   = 3;
  localparam logic [7:0] DEV_BYTE = 8'hA0;

  // {wr, addr[8], nacks[4], idle[3], stall, exp_starts[4], exp_to, exp_open, pad}
  localparam int NV = 6;
  localparam logic [23:0] VEC [NV] = '{
    {1'b1, 8'h3C, 4'd0, 3'd0, 1'b0, 4'd1, 1'b0, 1'b1, 1'b0},
    {1'b0, 8'h10, 4'd2, 3'd3, 1'b0, 4'd3, 1'b0, 1'b0, 1'b0},
    {1'b1, 8'hA5, 4'd4, 3'd0, 1'b1, 4'd5, 1'b0, 1'b1, 1'b0},
    {1'b0, 8'h00, 4'd5, 3'd1, 1'b1, 4'd5, 1'b1, 1'b0, 1'b0},
    {1'b1, 8'hFF, 4'd7, 3'd2, 1'b0, 4'd5, 1'b1, 1'b0, 1'b0},
    {1'b0, 8'h55, 4'd1, 3'd0, 1'b1, 4'd2, 1'b0, 1'b0, 1'b0}
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 1'b0, req_is_write = 1'b0;
  logic [7:0] req_word_addr = '0;
  logic req_ready, cmd_valid, cmd_ready, rsp_valid, rsp_ack, eng_idle;
  logic [1:0] cmd_op;
  logic [7:0] cmd_data;
  logic done, timeout, xfer_open;

  always #10 clk = ~clk;

  ackpoll_seq #(.DEV_ADDR(7'h50), .BYTE_W(8), .MAX_POLLS(TB_MAX), .GAP_CYCLES(TB_GAP)) uut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_is_write(req_is_write), .req_word_addr(req_word_addr),
    .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_op(cmd_op), .cmd_data(cmd_data),
    .rsp_valid(rsp_valid), .rsp_ack(rsp_ack), .eng_idle(eng_idle),
    .done(done), .timeout(timeout), .xfer_open(xfer_open));

  // Configuration and observation counters
  int cfg_nacks = 0, cfg_idle = 0;
  bit cfg_stall = 0;
  int n_start = 0, n_addr = 0, n_word = 0, n_stop = 0, bad_probe = 0;
  logic [7:0] last_word = '0;
  int n_done = 0, done_cyc = 0, rsp_cyc = 0, gap_bad = 0, nack_cyc = -1;
  bit seen_to = 0, seen_open = 0, early_done = 0;
  int cyc = 0, n_chk = 0, n_bad = 0;

  // Byte engine model
  logic [2:0] busy = '0;
  logic pend_ack = 1'b0, rdy_tog = 1'b0;
  logic [1:0] prev_op = 2'b11;
  int idle_hold = 0;

  assign cmd_ready = (busy == 0) && (!cfg_stall || rdy_tog);
  assign rsp_valid = (busy == 3'd1);
  assign rsp_ack   = pend_ack;
  assign eng_idle  = (busy == 0) && (idle_hold == 0);

  always @(posedge clk) begin
    rdy_tog <= ~rdy_tog;
    if (idle_hold > 0) idle_hold <= idle_hold - 1;
    if (busy != 0) begin
      busy <= busy - 1'b1;
      if (busy == 3'd1) idle_hold <= cfg_idle;
    end else if (cmd_valid && cmd_ready) begin
      busy    <= 3'd2;
      prev_op <= cmd_op;
      case (cmd_op)
        2'b00: n_start <= n_start + 1;
        2'b01: begin
          if (prev_op == 2'b00) begin
            if (cmd_data != DEV_BYTE) bad_probe <= bad_probe + 1;
            pend_ack <= (n_addr >= cfg_nacks);
            n_addr   <= n_addr + 1;
          end else begin
            pend_ack  <= 1'b1;
            n_word    <= n_word + 1;
            last_word <= cmd_data;
          end
        end
        2'b10: n_stop <= n_stop + 1;
        default: ;
      endcase
    end
  end

  // Monitor, sampled on the falling edge
  bit start_prev = 0;
  always @(negedge clk) begin
    if (rst_n) begin
      if (rsp_valid) rsp_cyc = cyc;
      if (rsp_valid && !rsp_ack && prev_op == 2'b01) nack_cyc = cyc;
      if (cmd_valid && cmd_op == 2'b00 && !start_prev && nack_cyc >= 0) begin
        if (cyc - nack_cyc != TB_GAP + 1) gap_bad++;
        nack_cyc = -1;
      end
      start_prev = cmd_valid && (cmd_op == 2'b00);
      if (done) begin
        n_done++;
        done_cyc  = cyc;
        seen_to   = timeout;
        seen_open = xfer_open;
        if (!eng_idle) early_done = 1;
      end
    end
  end

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc == 100000) begin
      n_bad++;
      $display("FAIL watchdog: act=%0d exp=%0d", cyc, 0);
      $display("  test done: total=%0d bad=%0d", n_chk + 1, n_bad);
      $finish;
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s act=%0d exp=%0d", req, act, exp);
    end
  endtask

  task automatic clear_obs();
    n_start = 0; n_addr = 0; n_word = 0; n_stop = 0; bad_probe = 0;
    n_done = 0; gap_bad = 0; nack_cyc = -1; early_done = 0;
    seen_to = 0; seen_open = 0;
  endtask

  task automatic run_vec(input logic [23:0] v);
    bit wr, eto, eopen;
    int starts, idl;
    wr = v[23]; idl = int'(v[10:8]); starts = int'(v[6:3]); eto = v[2]; eopen = v[1];
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    cfg_nacks = int'(v[14:11]); cfg_idle = idl; cfg_stall = v[7];
    clear_obs();
    req_valid = 1'b1; req_is_write = wr; req_word_addr = v[22:15];
    @(negedge clk);
    req_valid = 1'b0; req_word_addr = 8'h00;
    while (n_done == 0) begin
      @(negedge clk); #1;
    end
    repeat (6) @(negedge clk);
    // R3 every probe carries the device byte with write direction
    chk(bad_probe == 0 && n_addr == starts, "R3 probe bytes", bad_probe, 0);
    // R4 and R7 attempt count
    chk(n_start == starts, "R4/R7 start count", n_start, starts);
    // R4 gap after each refusal
    chk(gap_bad == 0, "R4 gap", gap_bad, 0);
    // R5 / R6 open flag and stop count
    chk(seen_open == eopen, "R5/R6 xfer_open", seen_open, eopen);
    chk(n_stop == (eopen ? 0 : 1), "R6 stop count", n_stop, eopen ? 0 : 1);
    if (eopen) chk(n_word == 1 && last_word == v[22:15], "R5 word byte", last_word, v[22:15]);
    else       chk(n_word == 0, "R6 no word byte", n_word, 0);
    // R7 timeout flag
    chk(seen_to == eto, "R7 timeout", seen_to, eto);
    // R8 one pulse, held until idle
    chk(n_done == 1 && !early_done, "R8 done count", n_done, 1);
    chk(done_cyc - rsp_cyc == idl + 1, "R8 done delay", done_cyc - rsp_cyc, idl + 1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(req_ready && !cmd_valid && !done, "R1 reset state",
        {req_ready, cmd_valid, done}, 3'b100);
    rst_n = 1'b1;
    for (int i = 0; i < NV; i++) run_vec(VEC[i]);

    // R1 reset in the middle of polling
    @(negedge clk);
    cfg_nacks = 15; cfg_idle = 0; cfg_stall = 0;
    clear_obs();
    req_valid = 1'b1; req_is_write = 1'b1; req_word_addr = 8'h77;
    @(negedge clk);
    req_valid = 1'b0;
    repeat (15) @(negedge clk);
    chk(!req_ready, "R1 busy before reset", req_ready, 0);
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    chk(req_ready && !cmd_valid && !done, "R1 mid-run reset",
        {req_ready, cmd_valid, done}, 3'b100);
    rst_n = 1'b1;
    repeat (8) @(negedge clk);
    run_vec({1'b1, 8'h42, 4'd1, 3'd2, 1'b0, 4'd2, 1'b0, 1'b1, 1'b0});

    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule